// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that sits behind a plain 32-bit register interface: an address, a write strobe, write data and combinational read data. Software drives output values and per-pin direction. It also reads back each pad's level after a two-flop synchronizer. The output enable toward the pads equals the direction bit, where 1 means output.

Each pin can raise an interrupt under one of five conditions: low level, high level, rising edge, falling edge, or either edge. The trigger is a 2-bit field per pin, held in two configuration words. A separate per-pin dual-edge register overrides that field. Detected events set sticky status bits. Software clears a status bit by writing a one to it. A mask register enables the pins. The enabled pending bits of pins 0–15 drive one interrupt line, and those of pins 16–31 drive a second line.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, every register reads zero, pad_oe is zero and both interrupt lines are low.
- R2: Offset 0x00 holds the output value and offset 0x04 the direction. A read of 0x00 returns the last written value, never the pad level. pad_out equals the 0x00 register and pad_oe equals the 0x04 register.
- R3: Offset 0x08 returns pad_in delayed by two clocks through a synchronizer. Writes to 0x08 have no effect.
- R4: Pin n takes its trigger from word 0x0C when n < 16, or from word 0x10 when n >= 16, at bits [2*(n mod 16)+1 : 2*(n mod 16)]. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. An edge is the synchronized value compared with its previous sample. A detected condition sets the status bit at the third clock edge after the pad change.
- R5: When a pin's bit in offset 0x1C is 1, the pin detects both rising and falling edges and its 2-bit trigger field is ignored.
- R6: Offset 0x18 holds the status. Writing 1 to a bit clears that bit, and a written 0 leaves the bit unchanged. Status bits otherwise stay set.
- R7: In a level mode the status bit is set again on every clock while the level holds.
- R8: If a detected event and a write-one clear hit the same bit on the same clock, the bit stays set.
- R9: Offset 0x14 is the mask, where 1 enables a pin. irq_lo is the OR of status AND mask over pins 0–15, and irq_hi is the same over pins 16–31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output values toward the pads |
| pad_oe | output | 32 | Output enables, 1 = drive |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The hardest case to reach from the ports is a write-one clear that lands on the same clock as a fresh detection on the same bit. The bench creates it by holding a pin at its active level in high-level mode and then clearing that bit. The level keeps producing an event on every clock, so the clear and the event always coincide, and the bit must read back as set. The dual-edge override is exercised on a pin whose own trigger field selects high level. After clearing the bit while the pad stays high, the status must remain clear.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] OFF_DATA = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_DIR  = 5'h04;
    localparam logic [ADDR_W-1:0] OFF_PAD  = 5'h08;
    localparam logic [ADDR_W-1:0] OFF_CFGL = 5'h0C;
    localparam logic [ADDR_W-1:0] OFF_CFGH = 5'h10;
    localparam logic [ADDR_W-1:0] OFF_MASK = 5'h14;
    localparam logic [ADDR_W-1:0] OFF_STAT = 5'h18;
    localparam logic [ADDR_W-1:0] OFF_BOTH = 5'h1C;

    typedef enum logic [1:0] {
        TRIG_LOW  = 2'b00,
        TRIG_HIGH = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_FALL = 2'b11
    } trig_mode_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0] cur,
    input  logic [NPINS-1:0] prev,
    input  logic [NPINS-1:0] cfg_lo,
    input  logic [NPINS-1:0] cfg_hi,
    input  logic [NPINS-1:0] both,
    output logic [NPINS-1:0] evt
);
    localparam int HALF = NPINS / 2;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic [1:0] fld;
        logic       hit;

        if (i < HALF) begin : g_lo
            assign fld = cfg_lo[2*i+1 -: 2];
        end else begin : g_hi
            assign fld = cfg_hi[2*(i-HALF)+1 -: 2];
        end

        always_comb begin
            hit = 1'b0;
            if (both[i]) begin
                hit = cur[i] ^ prev[i];
            end else begin
                unique case (trig_mode_e'(fld))
                    TRIG_LOW:  hit = ~cur[i];
                    TRIG_HIGH: hit = cur[i];
                    TRIG_RISE: hit = cur[i] & ~prev[i];
                    TRIG_FALL: hit = ~cur[i] & prev[i];
                endcase
            end
        end

        assign evt[i] = hit;
    end
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] evt,
    input  logic [NPINS-1:0] clr,
    input  logic [NPINS-1:0] mask,
    output logic [NPINS-1:0] st_q,
    output logic             irq_lo,
    output logic             irq_hi
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] st_d;
    logic [NPINS-1:0] live;

    always_comb begin
        st_d = (st_q & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live   = st_q & mask;
    assign irq_lo = |live[HALF-1:0];
    assign irq_hi = |live[NPINS-1:HALF];
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_lo,
    output logic              irq_hi
);
    logic [NPINS-1:0] dout_q, dir_q, cfgl_q, cfgh_q, mask_q, both_q;
    logic [NPINS-1:0] sync_q, prev_q, evt, clr, st_q;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(sync_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q;
    end

    gpio_trig_detect #(.NPINS(NPINS)) u_detect (
        .cur(sync_q), .prev(prev_q), .cfg_lo(cfgl_q), .cfg_hi(cfgh_q),
        .both(both_q), .evt(evt)
    );

    assign clr = (bus_we && bus_addr == OFF_STAT) ? bus_wdata : '0;

    gpio_irq_status #(.NPINS(NPINS)) u_status (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr), .mask(mask_q),
        .st_q(st_q), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
            cfgl_q <= '0;
            cfgh_q <= '0;
            mask_q <= '0;
            both_q <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFF_DATA: dout_q <= bus_wdata;
                OFF_DIR:  dir_q  <= bus_wdata;
                OFF_CFGL: cfgl_q <= bus_wdata;
                OFF_CFGH: cfgh_q <= bus_wdata;
                OFF_MASK: mask_q <= bus_wdata;
                OFF_BOTH: both_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_DATA: bus_rdata = dout_q;
            OFF_DIR:  bus_rdata = dir_q;
            OFF_PAD:  bus_rdata = sync_q;
            OFF_CFGL: bus_rdata = cfgl_q;
            OFF_CFGH: bus_rdata = cfgh_q;
            OFF_MASK: bus_rdata = mask_q;
            OFF_STAT: bus_rdata = st_q;
            OFF_BOTH: bus_rdata = both_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign pad_out = dout_q;
    assign pad_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  sync_q,
    input logic [NPINS-1:0]  st_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  evt,
    input logic              irq_lo,
    input logic              irq_hi
);
    localparam int HALF = NPINS / 2;

    logic [1:0]       age;
    logic [NPINS-1:0] wclr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd3)  age <= age + 2'd1;
    end

    assign wclr = (bus_we && bus_addr == OFF_STAT) ? bus_wdata : '0;

    // R9: nothing enabled means both lines stay low
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> (!irq_lo && !irq_hi));

    // R9: upper line needs a pending bit in the upper half
    a_r9_hi_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> (st_q[NPINS-1:HALF] != '0));

    // R8: a detected event is always recorded, even against a clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q & $past(evt)) == $past(evt)));

    // R6: written ones clear the bits that saw no event
    a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_STAT) |=> ((st_q & $past(bus_wdata) & ~$past(evt)) == '0));

    // R6: a set bit only falls through a written one
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q) & ~$past(wclr)) & ~st_q) == '0));

    // R2: output value follows a data write
    a_r2_out_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_DATA) |=> (pad_out == $past(bus_wdata)));

    // R3: synchronized pad lags the pins by two clocks
    a_r3_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (sync_q == $past(pad_in, 2)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .pad_in(pad_in), .pad_out(pad_out),
    .sync_q(sync_q), .st_q(st_q), .mask_q(mask_q), .evt(evt),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] bus_rdata, pad_out, pad_oe;
    logic        irq_lo, irq_hi;

    int checks = 0;
    int errors = 0;

    gpio_irq_port #(.NPINS(32)) i_gpio_irq_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #10 clk = ~clk;

    // behavioural reference
    logic [31:0] m_dout = '0, m_dir = '0, m_cfgl = '0, m_cfgh = '0;
    logic [31:0] m_mask = '0, m_st = '0, m_both = '0;
    logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_dout = '0; m_dir = '0; m_cfgl = '0; m_cfgh = '0;
            m_mask = '0; m_st = '0; m_both = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
        end else begin
            logic [31:0] ev;
            logic [31:0] cl;
            for (int n = 0; n < 32; n++) begin
                int md;
                md = (n < 16) ? int'((m_cfgl >> (2*n)) & 32'd3)
                              : int'((m_cfgh >> (2*(n-16))) & 32'd3);
                if (m_both[n]) ev[n] = (m_s2[n] != m_prev[n]);
                else case (md)
                    0: ev[n] = !m_s2[n];
                    1: ev[n] = m_s2[n];
                    2: ev[n] = m_s2[n] && !m_prev[n];
                    default: ev[n] = !m_s2[n] && m_prev[n];
                endcase
            end
            cl = (bus_we && bus_addr == 5'h18) ? bus_wdata : 32'h0;
            m_st = (m_st & ~cl) | ev;
            m_prev = m_s2;
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (bus_we) case (bus_addr)
                5'h00: m_dout = bus_wdata;
                5'h04: m_dir  = bus_wdata;
                5'h0C: m_cfgl = bus_wdata;
                5'h10: m_cfgh = bus_wdata;
                5'h14: m_mask = bus_wdata;
                5'h1C: m_both = bus_wdata;
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] mread(input logic [4:0] a);
        case (a)
            5'h00: return m_dout;
            5'h04: return m_dir;
            5'h08: return m_s2;
            5'h0C: return m_cfgl;
            5'h10: return m_cfgh;
            5'h14: return m_mask;
            5'h18: return m_st;
            5'h1C: return m_both;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00, 5'h04: return "R2 read";
            5'h08: return "R3 read";
            5'h0C, 5'h10: return "R4 read";
            5'h14: return "R9 read";
            5'h18: return "R6 read";
            5'h1C: return "R5 read";
            default: return "R1 read";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock, mid low phase
    always @(negedge clk) begin
        #5;
        chk("R9 irq_lo", {31'b0, irq_lo}, {31'b0, |(m_st[15:0] & m_mask[15:0])});
        chk("R9 irq_hi", {31'b0, irq_hi}, {31'b0, |(m_st[31:16] & m_mask[31:16])});
        chk("R2 pad_out", pad_out, m_dout);
        chk("R2 pad_oe", pad_oe, m_dir);
        chk(tag_of(bus_addr), bus_rdata, mread(bus_addr));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic expect_irq(input logic lo, input logic hi, input string tag);
        #1;
        chk(tag, {30'b0, irq_hi, irq_lo}, {30'b0, hi, lo});
    endtask

    initial begin
        #3_000_000;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(2);
        // R1 reset state
        for (int a = 0; a < 32; a += 4) expect_rd(5'(a), 32'h0, "R1 reg zero in reset");
        expect_irq(1'b0, 1'b0, "R1 irq low in reset");
        chk("R1 pad_oe in reset", pad_oe, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        tick(3);
        expect_rd(5'h18, 32'hFFFF_FFFF, "R7 default low-level sets all");
        expect_irq(1'b0, 1'b0, "R9 all masked");

        // R2 data / direction
        wr(5'h00, 32'hDEAD_BEEF);
        wr(5'h04, 32'h0000_FFFF);
        expect_rd(5'h00, 32'hDEAD_BEEF, "R2 data readback");
        chk("R2 pad_out", pad_out, 32'hDEAD_BEEF);
        chk("R2 pad_oe", pad_oe, 32'h0000_FFFF);
        pad_in = 32'h1234_5678;
        tick(3);
        expect_rd(5'h00, 32'hDEAD_BEEF, "R2 data not pad");
        expect_rd(5'h08, 32'h1234_5678, "R3 pad status");
        wr(5'h08, 32'hFFFF_FFFF);
        expect_rd(5'h08, 32'h1234_5678, "R3 write ignored");

        // all pins high level, clear, enable
        pad_in = 32'h0;
        wr(5'h0C, 32'h5555_5555);
        wr(5'h10, 32'h5555_5555);
        tick(3);
        wr(5'h18, 32'hFFFF_FFFF);
        expect_rd(5'h18, 32'h0, "R6 clear all");
        wr(5'h14, 32'hFFFF_FFFF);
        expect_irq(1'b0, 1'b0, "R9 nothing pending");

        // R4 pin3 rise, pin5 fall
        wr(5'h0C, 32'h5555_5D95);
        pad_in = 32'h0000_0028;
        tick(3);
        expect_rd(5'h18, 32'h0000_0008, "R4 rise pin3 only");
        expect_irq(1'b1, 1'b0, "R9 lower line");
        wr(5'h18, 32'h0000_0008);
        expect_rd(5'h18, 32'h0, "R6 clear pin3");
        pad_in = 32'h0000_0008;
        tick(3);
        expect_rd(5'h18, 32'h0000_0020, "R4 fall pin5");
        wr(5'h18, 32'h0000_0020);

        // R4 high level pin17, R8 collision, R7 persistence
        pad_in = 32'h0002_0008;
        tick(3);
        expect_rd(5'h18, 32'h0002_0000, "R4 high pin17");
        expect_irq(1'b0, 1'b1, "R9 upper line");
        wr(5'h18, 32'h0002_0000);
        expect_rd(5'h18, 32'h0002_0000, "R8 event beats clear");
        pad_in = 32'h0000_0008;
        tick(3);
        wr(5'h18, 32'h0002_0000);
        expect_rd(5'h18, 32'h0, "R7 clears once level gone");

        // R4 low level pin20
        wr(5'h10, 32'h5555_5455);
        tick(1);
        expect_rd(5'h18, 32'h0010_0000, "R4 low pin20");
        pad_in = 32'h0010_0008;
        tick(3);
        wr(5'h18, 32'h0010_0000);
        expect_rd(5'h18, 32'h0, "R7 low level released");

        // R5 both edges on pin9, field says high level
        wr(5'h1C, 32'h0000_0200);
        expect_rd(5'h1C, 32'h0000_0200, "R5 select readback");
        pad_in = 32'h0010_0208;
        tick(3);
        expect_rd(5'h18, 32'h0000_0200, "R5 rise");
        wr(5'h18, 32'h0000_0200);
        tick(3);
        expect_rd(5'h18, 32'h0, "R5 field ignored");
        pad_in = 32'h0010_0008;
        tick(3);
        expect_rd(5'h18, 32'h0000_0200, "R5 fall");

        // R6 zero write, R9 mask
        wr(5'h18, 32'h0);
        expect_rd(5'h18, 32'h0000_0200, "R6 zero write keeps");
        wr(5'h14, 32'h0);
        expect_irq(1'b0, 1'b0, "R9 masked off");
        wr(5'h14, 32'h0000_0200);
        expect_irq(1'b1, 1'b0, "R9 mask enables");
        wr(5'h14, 32'hFFFF_0000);
        expect_irq(1'b0, 1'b0, "R9 other half masked");
        wr(5'h18, 32'h0000_0200);
        expect_rd(5'h18, 32'h0, "R6 final clear");

        tick(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule